// File: doc/BRIEF.md
# Open-Drain I/O Port with Buzzer and Divider Outputs

This block is an 8-bit bidirectional general-purpose port controlled from the CPU. A single output latch holds the value the CPU writes. Static configuration inputs decide, pin by pin, whether the pin drives push-pull or works open-drain. An open-drain pin only ever pulls low or lets go. When it lets go, an external pull-up or another device sets the line level, so the pin can also be used as an input.

A CPU read returns the live pad levels, not the latch. Because of this, a single-bit set or clear is a read-modify-write of the pads: it can overwrite open-drain bits that an outside device is pulling low at that moment.

Two pins can be switched to drive a complementary buzzer pair from an external tone signal. The port's own latch bits gate the pair and shape it. A third pin can carry an external divider signal. An open-drain pin marked as a wake-up source raises a registered wake request when it is released and the line is low.

Top module: `gbp_port`

## Requirements
- R1: After reset the latch holds all ones, so every open-drain pin is released (pad_oe low) and reads 1 when nothing outside pulls it.
- R2: A cycle with wr_en high loads wr_data into the latch at that clock edge. The latch keeps its value on every cycle without wr_en or bop_en.
- R3: rd_data always equals the present pad_in levels, with no register in the path. The latch contents are not returned.
- R4: An open-drain pin (cfg_pushpull bit 0) has pad_out 0 and pad_oe equal to the inverse of its latch bit. It never drives a high level.
- R5: A push-pull pin (cfg_pushpull bit 1) always has pad_oe high. With no override active, its pad_out equals its latch bit.
- R6: The buzzer pair uses pin 0 and pin 1, and is active when cfg_buzzer_en is 1 and both pins are push-pull. Latch bit 0 = 1 drives both pins to 0. Latch bits 0 and 1 both 0 drive pin 0 = tone_in and pin 1 = NOT tone_in. Latch bit 0 = 0 with bit 1 = 1 drives pin 0 = tone_in and pin 1 = 0.
- R7: Pin 3 drives pfd_in when cfg_pfd_en is 1 and pin 3 is push-pull. When pin 3 is open-drain, cfg_pfd_en has no effect and the pin follows R4.
- R8: wake_req goes high one clock after a pin meets all four conditions: it has cfg_wake_en set, it is open-drain, its latch bit is 1, and its pad_in is 0. A push-pull pin, or an open-drain pin with latch bit 0, never causes a wake request.
- R9: A cycle with bop_en high loads all of pad_in into the latch, with bit bop_idx replaced by bop_set (1 sets, 0 clears).
- R10: When wr_en and bop_en are high in the same cycle, the write wins and the bit operation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe for the latch |
| wr_data | input | 8 | Data to load into the latch |
| bop_en | input | 1 | Single-bit set/clear strobe (read-modify-write) |
| bop_set | input | 1 | Value for the selected bit: 1 set, 0 clear |
| bop_idx | input | 3 | Index of the selected bit |
| rd_data | output | 8 | Live pad levels for a CPU read |
| cfg_pushpull | input | 8 | Per pin: 1 push-pull, 0 open-drain |
| cfg_wake_en | input | 8 | Per pin wake-up source enable |
| cfg_buzzer_en | input | 1 | Route the tone pair to pins 0 and 1 |
| cfg_pfd_en | input | 1 | Route pfd_in to pin 3 |
| tone_in | input | 1 | Buzzer tone signal |
| pfd_in | input | 1 | Divider output signal |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| wake_req | output | 1 | Registered wake-up request |

## Verification
The bench builds the port with its defaults: eight pins, the buzzer pair on pins 0 and 1, and the divider on pin 3. With these settings every buzzer truth-table row and both pin-3 modes can be reached directly. The bench models the pads as resolved wires with pull-ups, so an external low on a released open-drain line shows up on rd_data. This makes the read-modify-write corruption of R9 visible as a bit the CPU never cleared.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

  // Buzzer pair value {pin_b, pin_a} from latch bits and tone.
  function automatic logic [1:0] buzz_pair(input logic lat_a, input logic lat_b,
                                           input logic tone);
    logic [1:0] r;
    if (lat_a)       r = 2'b00;
    else if (lat_b)  r = {1'b0, tone};
    else             r = {~tone, tone};
    return r;
  endfunction

endpackage

// File: rtl/gbp_latch.sv
module gbp_latch #(
  parameter int WIDTH = 8,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             bop_en,
  input  logic             bop_set,
  input  logic [IDXW-1:0]  bop_idx,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] latch_q,
  output logic             wr_evt,
  output logic             bop_evt
);

  function automatic logic [WIDTH-1:0] rmw_merge(input logic [WIDTH-1:0] pads,
                                                 input logic [IDXW-1:0] idx,
                                                 input logic val);
    logic [WIDTH-1:0] r;
    r = pads;
    r[idx] = val;
    return r;
  endfunction

  assign wr_evt  = wr_en;
  assign bop_evt = bop_en && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n)       latch_q <= '1;
    else if (wr_evt)  latch_q <= wr_data;
    else if (bop_evt) latch_q <= rmw_merge(pad_in, bop_idx, bop_set);
  end

endmodule

// File: rtl/gbp_pin_mux.sv
module gbp_pin_mux
  import gbp_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int BZ_A    = 0,
  parameter int BZ_B    = 1,
  parameter int PFD_PIN = 3
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] cfg_pushpull,
  input  logic             cfg_buzzer_en,
  input  logic             cfg_pfd_en,
  input  logic             tone_in,
  input  logic             pfd_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic             bz_active,
  output logic             pfd_active
);

  logic [1:0]       pair;
  logic [WIDTH-1:0] pp_val;

  assign bz_active  = cfg_buzzer_en && cfg_pushpull[BZ_A] && cfg_pushpull[BZ_B];
  assign pfd_active = cfg_pfd_en && cfg_pushpull[PFD_PIN];
  assign pair       = buzz_pair(latch_q[BZ_A], latch_q[BZ_B], tone_in);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i == BZ_A) begin : g_bza
      assign pp_val[i] = bz_active ? pair[0] : latch_q[i];
    end else if (i == BZ_B) begin : g_bzb
      assign pp_val[i] = bz_active ? pair[1] : latch_q[i];
    end else if (i == PFD_PIN) begin : g_pfd
      assign pp_val[i] = pfd_active ? pfd_in : latch_q[i];
    end else begin : g_plain
      assign pp_val[i] = latch_q[i];
    end

    always_comb begin
      if (cfg_pushpull[i]) begin
        pad_oe[i]  = 1'b1;
        pad_out[i] = pp_val[i];
      end else begin
        pad_oe[i]  = ~latch_q[i];
        pad_out[i] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/gbp_wake.sv
module gbp_wake #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] cfg_pushpull,
  input  logic [WIDTH-1:0] cfg_wake_en,
  output logic             wake_hit,
  output logic             wake_req
);

  assign wake_hit = |(cfg_wake_en & ~cfg_pushpull & latch_q & ~pad_in);

  always_ff @(posedge clk) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= wake_hit;
  end

endmodule

// File: rtl/gbp_port.sv
module gbp_port #(
  parameter int WIDTH   = 8,
  parameter int BZ_A    = 0,
  parameter int BZ_B    = 1,
  parameter int PFD_PIN = 3,
  localparam int IDXW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             bop_en,
  input  logic             bop_set,
  input  logic [IDXW-1:0]  bop_idx,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] cfg_pushpull,
  input  logic [WIDTH-1:0] cfg_wake_en,
  input  logic             cfg_buzzer_en,
  input  logic             cfg_pfd_en,
  input  logic             tone_in,
  input  logic             pfd_in,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic             wake_req
);

  logic [WIDTH-1:0] latch_q;
  logic             wr_evt, bop_evt, bz_active, pfd_active, wake_hit;

  // Reads are not registered: the pads are returned as they are now.
  assign rd_data = pad_in;

  gbp_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bop_en(bop_en), .bop_set(bop_set), .bop_idx(bop_idx), .pad_in(pad_in),
    .latch_q(latch_q), .wr_evt(wr_evt), .bop_evt(bop_evt)
  );

  gbp_pin_mux #(.WIDTH(WIDTH), .BZ_A(BZ_A), .BZ_B(BZ_B), .PFD_PIN(PFD_PIN)) u_mux (
    .latch_q(latch_q), .cfg_pushpull(cfg_pushpull), .cfg_buzzer_en(cfg_buzzer_en),
    .cfg_pfd_en(cfg_pfd_en), .tone_in(tone_in), .pfd_in(pfd_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .bz_active(bz_active), .pfd_active(pfd_active)
  );

  gbp_wake #(.WIDTH(WIDTH)) u_wake (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .latch_q(latch_q),
    .cfg_pushpull(cfg_pushpull), .cfg_wake_en(cfg_wake_en),
    .wake_hit(wake_hit), .wake_req(wake_req)
  );

endmodule

// File: rtl/gbp_port_chk.sv
module gbp_port_chk #(
  parameter int WIDTH = 8,
  parameter int BZ_A  = 0,
  parameter int BZ_B  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             bop_en,
  input logic [WIDTH-1:0] latch_q,
  input logic [WIDTH-1:0] cfg_pushpull,
  input logic [WIDTH-1:0] cfg_wake_en,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic             bz_active,
  input logic             wake_req
);

  a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !bop_en) |=> $stable(latch_q));

  a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cfg_pushpull & pad_oe & pad_out) != '0) |-> 1'b0);

  a_r5_pp_drives: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pushpull != '0 |-> ((pad_oe & cfg_pushpull) == cfg_pushpull));

  a_r6_bz_silenced: assert property (@(posedge clk) disable iff (!rst_n)
    (bz_active && latch_q[BZ_A]) |-> (!pad_out[BZ_A] && !pad_out[BZ_B]));

  a_r8_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past((cfg_wake_en & ~cfg_pushpull) != '0));

endmodule

bind gbp_port gbp_port_chk #(.WIDTH(WIDTH), .BZ_A(BZ_A), .BZ_B(BZ_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bop_en(bop_en), .latch_q(latch_q),
  .cfg_pushpull(cfg_pushpull), .cfg_wake_en(cfg_wake_en), .pad_out(pad_out),
  .pad_oe(pad_oe), .bz_active(bz_active), .wake_req(wake_req)
);

// File: tb/sim_gbp_port.sv
`timescale 1ns/1ps
module sim_gbp_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, bop_en = 1'b0, bop_set = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] bop_idx = '0;
  logic [7:0] rd_data, pad_out, pad_oe, pad_in;
  logic [7:0] cfg_pushpull = '0, cfg_wake_en = '0;
  logic       cfg_buzzer_en = 1'b0, cfg_pfd_en = 1'b0, tone_in = 1'b0, pfd_in = 1'b0;
  logic       wake_req;
  logic [7:0] ext_low = '0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  // Pad model: driven pins follow the port, released pins are pulled up unless held low.
  for (genvar i = 0; i < 8; i++) begin : g_pad
    assign pad_in[i] = pad_oe[i] ? pad_out[i] : ~ext_low[i];
  end

  gbp_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .bop_en(bop_en),
    .bop_set(bop_set), .bop_idx(bop_idx), .rd_data(rd_data),
    .cfg_pushpull(cfg_pushpull), .cfg_wake_en(cfg_wake_en),
    .cfg_buzzer_en(cfg_buzzer_en), .cfg_pfd_en(cfg_pfd_en), .tone_in(tone_in),
    .pfd_in(pfd_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(); #1; endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; settle();
  endtask

  task automatic do_bop(input logic [2:0] idx, input logic val);
    @(negedge clk); bop_en = 1'b1; bop_idx = idx; bop_set = val;
    @(negedge clk); bop_en = 1'b0; settle();
  endtask

  task automatic t_reset();
    settle();
    chk("R1 oe after reset", pad_oe, 8'h00);
    chk("R1 read after reset", rd_data, 8'hFF);
  endtask

  task automatic t_write_od();
    cfg_pushpull = 8'h00;
    do_write(8'h5A);
    chk("R4 od oe", pad_oe, 8'hA5);
    chk("R4 od out", pad_out, 8'h00);
    repeat (3) @(negedge clk); settle();
    chk("R2 latch held", rd_data, 8'h5A);
  endtask

  task automatic t_live_read();
    do_write(8'hFF);
    @(negedge clk); ext_low = 8'h0F; settle();
    chk("R3 read follows pads", rd_data, 8'hF0);
    ext_low = 8'h00; settle();
    chk("R3 read after release", rd_data, 8'hFF);
  endtask

  task automatic t_pushpull();
    cfg_pushpull = 8'hFF;
    do_write(8'h3C);
    chk("R5 pp oe", pad_oe, 8'hFF);
    chk("R5 pp out", pad_out, 8'h3C);
    ext_low = 8'hFF; settle();
    chk("R5 pp ignores outside", rd_data, 8'h3C);
    ext_low = 8'h00;
    cfg_pushpull = 8'h00;
  endtask

  task automatic t_buzzer();
    cfg_pushpull = 8'h0B; cfg_buzzer_en = 1'b1;
    do_write(8'h00);
    tone_in = 1'b1; settle(); chk("R6 b00 tone1", pad_out[1:0], 2'b01);
    tone_in = 1'b0; settle(); chk("R6 b00 tone0", pad_out[1:0], 2'b10);
    do_write(8'h02);
    tone_in = 1'b1; settle(); chk("R6 b10 tone1", pad_out[1:0], 2'b01);
    tone_in = 1'b0; settle(); chk("R6 b10 tone0", pad_out[1:0], 2'b00);
    do_write(8'h01);
    tone_in = 1'b1; settle(); chk("R6 bit0 set", pad_out[1:0], 2'b00);
    do_write(8'h02); cfg_buzzer_en = 1'b0; settle();
    chk("R6 buzzer off", pad_out[1:0], 2'b10);
    cfg_pushpull = 8'h00; tone_in = 1'b0;
  endtask

  task automatic t_pfd();
    cfg_pushpull = 8'h08; cfg_pfd_en = 1'b1;
    do_write(8'h00);
    pfd_in = 1'b1; settle(); chk("R7 pfd high", pad_out[3], 1'b1);
    pfd_in = 1'b0; settle(); chk("R7 pfd low", pad_out[3], 1'b0);
    cfg_pushpull = 8'h00; pfd_in = 1'b1;
    do_write(8'hFF);
    chk("R7 od pin3 released", {pad_oe[3], pad_out[3]}, 2'b00);
    do_write(8'hF7);
    chk("R7 od pin3 pulls low", {pad_oe[3], pad_out[3]}, 2'b10);
    cfg_pfd_en = 1'b0; pfd_in = 1'b0;
  endtask

  task automatic t_wake();
    cfg_pushpull = 8'h00; cfg_wake_en = 8'h20;
    do_write(8'hFF);
    ext_low = 8'h01; @(negedge clk); settle();
    chk("R8 other pin no wake", wake_req, 1'b0);
    ext_low = 8'h20; settle();
    chk("R8 wake registered", wake_req, 1'b0);
    @(negedge clk); settle();
    chk("R8 wake raised", wake_req, 1'b1);
    cfg_pushpull = 8'h20; @(negedge clk); settle();
    chk("R8 pp no wake", wake_req, 1'b0);
    cfg_pushpull = 8'h00;
    do_write(8'hDF); @(negedge clk); settle();
    chk("R8 latch low no wake", wake_req, 1'b0);
    ext_low = 8'h00; cfg_wake_en = 8'h00;
  endtask

  task automatic t_rmw();
    cfg_pushpull = 8'h00;
    do_write(8'hFF);
    @(negedge clk); ext_low = 8'h04;
    do_bop(3'd7, 1'b1);
    ext_low = 8'h00; settle();
    chk("R9 rmw captured low pad", rd_data, 8'hFB);
    chk("R9 rmw oe", pad_oe, 8'h04);
    do_bop(3'd0, 1'b0);
    chk("R9 bit clear", rd_data, 8'hFA);
  endtask

  task automatic t_priority();
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h11; bop_en = 1'b1; bop_idx = 3'd7; bop_set = 1'b1;
    @(negedge clk); wr_en = 1'b0; bop_en = 1'b0; settle();
    chk("R10 write wins", rd_data, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_od();
    t_live_read();
    t_pushpull();
    t_buzzer();
    t_pfd();
    t_wake();
    t_rmw();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule